// File: doc/BRIEF.md
# One-Shot / Periodic Local Interrupt Timer

This block is the counting core of a per-processor interrupt timer. Software-facing logic outside the block writes a 32-bit initial count and a small control word. The control word holds a power-of-two divide shift, a mode bit and a mask bit. From the moment an initial count is written, the block counts divided ticks. It exposes a current-count value that can be read in any cycle, and it raises a one-cycle expiry pulse when the programmed interval runs out.

In one-shot mode the timer fires once, `initial + 1` divided ticks after the write, and then reads zero. In periodic mode it fires every `initial + 1` divided ticks, and its count reloads to the initial value after each wrap. A zero initial count in periodic mode keeps the timer silent. The mask bit suppresses expiry pulses but does not stop counting. Vector delivery, prioritisation and register decode live in neighbouring blocks.

Top module: `irq_local_timer`

## Requirements
- R1: After reset the current count reads 0 and no expiry occurs. The control state is masked, one-shot, with shift 0, and the initial count is 0, so a later count write without a control write never produces an expiry.
- R2: When `cnt_we` is high at a clock edge, the initial count takes `cnt_wdata` and counting restarts. In the following cycle `cur_count` equals the written value.
- R3: A divided tick occurs on each edge where the number of edges since the last count write is a multiple of 2^shift. A control write changes the shift from the following edge onward. Tick boundaries stay aligned to the write point, and ticks already counted are kept.
- R4: In periodic mode (`ctl_periodic`=1), `cur_count` = initial − (ticks mod (initial+1)).
- R5: In one-shot mode (`ctl_periodic`=0), `cur_count` = initial − ticks, and it reads 0 once ticks ≥ initial. With no writes it stays 0 from then on.
- R6: In periodic mode with a nonzero initial count, `expire` is high for the cycle after each edge at which ticks reach a multiple of initial+1.
- R7: In one-shot mode, `expire` is high once, after the edge at which ticks reach initial+1. If that point has already passed when the mode is switched to one-shot, no expiry occurs.
- R8: In periodic mode with an initial count of 0, `expire` never rises.
- R9: While the mask bit (`ctl_mask`=1) is set, `expire` stays low, and the count keeps advancing.
- R10: `expire` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_we | input | 1 | Write strobe for the initial count |
| cnt_wdata | input | 32 | Initial count value |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_shift | input | 3 | Divide shift; a tick occurs every 2^shift cycles |
| ctl_periodic | input | 1 | 1 = periodic, 0 = one-shot |
| ctl_mask | input | 1 | 1 = expiry suppressed |
| cur_count | output | 32 | Current count |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
The hardest state to reach is a change of mode or shift in the middle of a count. The intended outcome is that the existing write point survives: tick boundaries stay aligned to it, and a one-shot deadline that has already passed must never fire. Directed sequences load a periodic count, let it wrap several times, and then switch to one-shot. Other directed sequences change the shift a few ticks after a load. Random traffic then mixes count writes, control writes and masking across every cycle, and each cycle is compared with a model of elapsed ticks kept in the bench.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic {
    LT_ONESHOT  = 1'b0,
    LT_PERIODIC = 1'b1
  } lt_mode_e;
endpackage

// File: rtl/lt_rst_sync.sv
module lt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] pre_inc;
  logic [PRE_W-1:0] low_mask;

  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign low_mask[g] = (shift > SHIFT_W'(g));
  end

  always_comb begin
    pre_inc = pre_q + PRE_W'(1);
    pre_d   = restart ? '0 : pre_inc;
    tick    = !restart && ((pre_inc & low_mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/lt_elapsed.sv
module lt_elapsed #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] init,
  output logic [CNT_W:0]   ticks,
  output logic [CNT_W-1:0] rem,
  output logic             at_wrap,
  output logic             at_deadline
);
  logic [CNT_W:0]   ticks_q, ticks_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             ticks_en, rem_en;

  always_comb begin
    at_wrap     = (rem_q == init);
    at_deadline = (ticks_q == {1'b0, init});
    ticks_en    = restart || (tick && !(&ticks_q));
    rem_en      = restart || tick;
    ticks_d     = restart ? '0 : ticks_q + (CNT_W+1)'(1);
    if (restart)      rem_d = '0;
    else if (at_wrap) rem_d = '0;
    else              rem_d = rem_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ticks_q <= '0;
    else if (ticks_en) ticks_q <= ticks_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign ticks = ticks_q;
  assign rem   = rem_q;
endmodule

// File: rtl/lt_view.sv
module lt_view
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  lt_mode_e         mode,
  input  logic [CNT_W-1:0] init,
  input  logic [CNT_W:0]   ticks,
  input  logic [CNT_W-1:0] rem,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    if (mode == LT_PERIODIC)           count = init - rem;
    else if (ticks >= {1'b0, init})    count = '0;
    else                               count = init - ticks[CNT_W-1:0];
  end
endmodule

// File: rtl/irq_local_timer.sv
module irq_local_timer
  import lt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SHIFT_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               ctl_we,
  input  logic [SHIFT_W-1:0] ctl_shift,
  input  logic               ctl_periodic,
  input  logic               ctl_mask,
  output logic [CNT_W-1:0]   cur_count,
  output logic               expire
);
  logic               rst_sync_n;
  logic [CNT_W-1:0]   init_q, init_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  lt_mode_e           mode_q, mode_d;
  logic               mask_q, mask_d;
  logic               expire_q, expire_d;
  logic               tick;
  logic [CNT_W:0]     ticks;
  logic [CNT_W-1:0]   rem;
  logic               at_wrap, at_deadline;

  lt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .restart(cnt_we),
    .shift(shift_q), .tick(tick)
  );

  lt_elapsed #(.CNT_W(CNT_W)) u_elapsed (
    .clk(clk), .rst_n(rst_sync_n), .restart(cnt_we), .tick(tick),
    .init(init_q), .ticks(ticks), .rem(rem),
    .at_wrap(at_wrap), .at_deadline(at_deadline)
  );

  lt_view #(.CNT_W(CNT_W)) u_view (
    .mode(mode_q), .init(init_q), .ticks(ticks), .rem(rem),
    .count(cur_count)
  );

  always_comb begin
    init_d  = cnt_wdata;
    shift_d = ctl_shift;
    mode_d  = ctl_periodic ? LT_PERIODIC : LT_ONESHOT;
    mask_d  = ctl_mask;
    expire_d = 1'b0;
    if (tick && !mask_q) begin
      if (mode_q == LT_PERIODIC) expire_d = at_wrap && (init_q != '0);
      else                       expire_d = at_deadline;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  init_q <= '0;
    else if (cnt_we)  init_q <= init_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      shift_q <= '0;
      mode_q  <= LT_ONESHOT;
      mask_q  <= 1'b1;
    end else if (ctl_we) begin
      shift_q <= shift_d;
      mode_q  <= mode_d;
      mask_q  <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) expire_q <= 1'b0;
    else             expire_q <= expire_d;
  end

  assign expire = expire_q;
endmodule

// File: rtl/lt_checker.sv
module lt_checker
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_we,
  input logic             ctl_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cur_count,
  input logic             expire,
  input logic [CNT_W-1:0] init_q,
  input lt_mode_e         mode_q,
  input logic             mask_q
);
  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cur_count == $past(cnt_wdata));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LT_ONESHOT && cur_count == '0 && !cnt_we && !ctl_we) |=> cur_count == '0);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_count <= init_q);

  // R8
  zero_period_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LT_PERIODIC && init_q == '0) |=> !expire);

  // R9
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> !expire);

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

bind irq_local_timer lt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_we(cnt_we), .ctl_we(ctl_we),
  .cnt_wdata(cnt_wdata), .cur_count(cur_count), .expire(expire),
  .init_q(init_q), .mode_q(mode_q), .mask_q(mask_q)
);

// File: tb/irq_local_timer_tb.sv
module irq_local_timer_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_we, ctl_we, ctl_periodic, ctl_mask;
  logic [31:0] cnt_wdata;
  logic [2:0]  ctl_shift;
  logic [31:0] cur_count;
  logic        expire;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  longint m_init, m_c, m_ticks;
  int     m_shift;
  bit     m_per, m_mask, m_exp, prev_exp;
  int     exp_seen;

  always #(CLK_P/2) clk = ~clk;

  irq_local_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ctl_we(ctl_we), .ctl_shift(ctl_shift), .ctl_periodic(ctl_periodic),
    .ctl_mask(ctl_mask), .cur_count(cur_count), .expire(expire)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_count();
    if (m_per) return m_init - (m_ticks % (m_init + 1));
    if (m_ticks >= m_init) return 0;
    return m_init - m_ticks;
  endfunction

  task automatic model_edge(input bit we, input logic [31:0] d, input bit cwe,
                            input int sh, input bit per, input bit msk);
    bit fire = 0;
    if (we) begin
      m_c = 0; m_ticks = 0; m_init = longint'(d);
    end else begin
      m_c++;
      if ((m_c % (longint'(1) << m_shift)) == 0) begin
        m_ticks++;
        if (!m_mask) begin
          if (m_per) fire = (m_init != 0) && ((m_ticks % (m_init + 1)) == 0);
          else       fire = (m_ticks == m_init + 1);
        end
      end
    end
    m_exp = fire;
    if (cwe) begin
      m_shift = sh; m_per = per; m_mask = msk;
    end
  endtask

  task automatic compare();
    string ctag, etag;
    ctag = m_per ? "R4" : "R5";
    if (m_mask)                    etag = "R9";
    else if (m_per && m_init == 0) etag = "R8";
    else if (m_per)                etag = "R6";
    else                           etag = "R7";
    chk(longint'(cur_count) == exp_count(), ctag, longint'(cur_count), exp_count());
    chk(expire == m_exp, etag, longint'(expire), longint'(m_exp));
    if (expire) begin
      chk(!prev_exp, "R10", 1, 0);
      exp_seen++;
    end
    prev_exp = expire;
  endtask

  task automatic step(input bit we, input logic [31:0] d, input bit cwe,
                      input int sh, input bit per, input bit msk);
    cnt_we = we; cnt_wdata = d; ctl_we = cwe;
    ctl_shift = 3'(sh); ctl_periodic = per; ctl_mask = msk;
    @(posedge clk);
    model_edge(we, d, cwe, sh, per, msk);
    @(negedge clk);
    cnt_we = 0; ctl_we = 0;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic ctl(input int sh, input bit per, input bit msk);
    step(0, 0, 1, sh, per, msk);
  endtask

  task automatic load(input logic [31:0] d);
    step(1, d, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; cnt_we = 0; ctl_we = 0; cnt_wdata = 0;
    ctl_shift = 0; ctl_periodic = 0; ctl_mask = 0;
    m_init = 0; m_c = 0; m_ticks = 0; m_shift = 0;
    m_per = 0; m_mask = 1; m_exp = 0; prev_exp = 0; exp_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(cur_count == 0, "R1", longint'(cur_count), 0);
    chk(expire == 0, "R1", longint'(expire), 0);
    // R1: default control is masked, so a load alone never expires
    exp_seen = 0;
    load(32'd3);
    idle(8);
    chk(exp_seen == 0, "R1", exp_seen, 0);

    // R2: load restarts and count shows value next cycle
    ctl(0, 0, 0);
    load(32'h1234);
    chk(cur_count == 32'h1234, "R2", longint'(cur_count), 32'h1234);
    load(32'd5);
    exp_seen = 0;
    idle(12);
    chk(exp_seen == 1, "R7", exp_seen, 1);
    chk(cur_count == 0, "R5", longint'(cur_count), 0);

    // R6: periodic, init 2, shift 1 -> expiry every 6 cycles
    ctl(1, 1, 0);
    load(32'd2);
    exp_seen = 0;
    idle(30);
    chk(exp_seen == 5, "R6", exp_seen, 5);

    // R8: periodic with zero initial count
    load(32'd0);
    exp_seen = 0;
    idle(20);
    chk(exp_seen == 0, "R8", exp_seen, 0);

    // R7: switch to one-shot after the deadline has passed
    ctl(0, 1, 0);
    load(32'd2);
    idle(10);
    ctl(0, 0, 0);
    exp_seen = 0;
    idle(10);
    chk(exp_seen == 0, "R7", exp_seen, 0);
    chk(cur_count == 0, "R5", longint'(cur_count), 0);

    // R3: shift change mid-count keeps load-point alignment (expect 10-6)
    ctl(0, 1, 0);
    load(32'd10);
    idle(3);
    ctl(2, 1, 0);
    idle(8);
    chk(cur_count == 4, "R3", longint'(cur_count), 4);

    // R9: masked periodic keeps counting without expiry
    ctl(0, 1, 1);
    load(32'd1);
    exp_seen = 0;
    idle(9);
    chk(exp_seen == 0, "R9", exp_seen, 0);
    chk(cur_count == 0, "R9", longint'(cur_count), 0);

    // R4: full-range initial count
    ctl(0, 1, 0);
    load(32'hFFFF_FFFF);
    idle(5);
    chk(cur_count == 32'hFFFF_FFFA, "R4", longint'(cur_count), 32'hFFFF_FFFA);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we, cwe, per, msk;
      logic [31:0] d;
      int sh;
      we  = ($urandom % 40) == 0;
      d   = (($urandom % 4) == 0) ? 32'($urandom % 3) : 32'($urandom % 40);
      cwe = ($urandom % 25) == 0;
      sh  = (($urandom % 6) == 0) ? int'($urandom % 8) : int'($urandom % 3);
      per = $urandom % 2;
      msk = ($urandom % 5) == 0;
      step(we, d, cwe, sh, per, msk);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule